// File: doc/BRIEF.md
# Dual-Port Inter-Processor Mailbox

This block lets two processors, side A and side B, pass 32-bit messages to each other through eight one-way channels. Each side reaches the mailbox through its own single-cycle register port (request, write strobe, byte address, write data, registered read data) and receives its own interrupt line. Every channel is a small FIFO. The direction of each channel decides which side may push into it and which side may pop from it. Either side can set that direction by writing a control word, and each side reads the direction relative to itself.

Each side owns a bank of interrupt status bits, with two bits per channel, and a matching enable register. A receive bit rises when the channel holds data. A transmit bit rises when the channel has room. A receive bit cannot be cleared while its FIFO still holds messages. A sender can read the peer's status bank, so when the receiver's bit drops, the sender knows the message has been consumed.

The register map is by byte address. Control words start at 0x000, one word per four channels. The peer enable register is at 0x040 and the peer status register at 0x050. The own enable register is at 0x060 and the own status register at 0x070. Per-channel full flags start at 0x100, counts at 0x140, and data ports at 0x180, each with a stride of 4.

Top module: `ipc_mailbox`

## Requirements
- R1: After reset, all FIFOs are empty, every channel has side A as sender, all enables and status bits are 0, and both interrupt lines are low.
- R2: In control word w at 0x000+4w, channel n=4w+j reports bit 8j set when the reading side receives on that channel and bit 8j+4 set when the reading side sends on it. A write with exactly one of these two bits set makes the writer receiver or sender accordingly. A write with both bits set or both clear leaves that channel unchanged.
- R3: A write to 0x180+4n from the sender pushes a message. A read of that address by the receiver pops messages in arrival order, with the message on read data one cycle after the request. 0x140+4n reports the count in bits 2:0, and 0x100+4n bit 0 reports full, meaning 4 messages are held.
- R4: A push to a full FIFO is dropped. A pop from an empty FIFO returns 0 and leaves the FIFO unchanged.
- R5: A data write from the receiver and a data read from the sender are ignored: the count is unchanged and a read of this kind returns 0.
- R6: The receiver's status bit 2n is set while channel n holds data. Writing 1 to it at 0x070 clears it only when the FIFO is empty.
- R7: The sender's status bit 2n+1 is set while channel n is not full. Writing 1 to it clears it, and it sets again whenever there is room.
- R8: Writing 0x060 sets the own enable bits. A side's interrupt line is the OR of its status bits ANDed with its enable bits.
- R9: 0x040 and 0x050 return the peer's enable and status registers. Writes to those two addresses are ignored.
- R10: A push and a pop on the same channel in the same cycle both take effect, including when the FIFO is full. When the FIFO is empty, only the push takes effect and the read returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| a_req | input | 1 | Side A access request |
| a_we | input | 1 | Side A write strobe |
| a_addr | input | 10 | Side A byte address |
| a_wdata | input | 32 | Side A write data |
| a_rdata | output | 32 | Side A read data, one cycle after request |
| a_irq | output | 1 | Side A interrupt |
| b_req | input | 1 | Side B access request |
| b_we | input | 1 | Side B write strobe |
| b_addr | input | 10 | Side B byte address |
| b_wdata | input | 32 | Side B write data |
| b_rdata | output | 32 | Side B read data, one cycle after request |
| b_irq | output | 1 | Side B interrupt |

## Verification
The bench targets the clear rule on a non-empty FIFO. A design that let that clear through would drop the receive bit early, and the sender would read the peer status as acknowledged before the message was consumed. It targets a push and a pop landing on a full FIFO in the same cycle. A design that tested full before the pop would lose the new message and leave the count at 3 on a later read. It targets data accesses from the wrong side. A mistake there would move the count or hand the sender a message it had not received. Direction writes with both bits set, and writes to the peer registers, are also checked: a faulty design would flip the direction or change the peer's enable.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam int unsigned MB_ADDR_W = 10;

  typedef enum logic [3:0] {
    RG_CTRL, RG_PEER_EN, RG_PEER_ST, RG_OWN_EN, RG_OWN_ST,
    RG_FULL, RG_CNT, RG_DATA, RG_NONE
  } reg_kind_e;

  typedef struct packed {
    reg_kind_e  kind;
    logic [3:0] idx;
  } dec_t;

  // Byte address to register kind and channel or word index.
  function automatic dec_t decode(input logic [MB_ADDR_W-1:0] addr);
    dec_t d;
    logic [7:0] w;
    w      = addr[9:2];
    d.kind = RG_NONE;
    d.idx  = w[3:0];
    if (w < 8'd4)              d.kind = RG_CTRL;
    else if (w == 8'd16)       d.kind = RG_PEER_EN;
    else if (w == 8'd20)       d.kind = RG_PEER_ST;
    else if (w == 8'd24)       d.kind = RG_OWN_EN;
    else if (w == 8'd28)       d.kind = RG_OWN_ST;
    else if (w[7:4] == 4'h4)   d.kind = RG_FULL;
    else if (w[7:4] == 4'h5)   d.kind = RG_CNT;
    else if (w[7:4] == 4'h6)   d.kind = RG_DATA;
    return d;
  endfunction
endpackage

// File: rtl/mbox_fifo.sv
module mbox_fifo #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned DEPTH  = 4
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             push,
  input  logic [DATA_W-1:0]                push_data,
  input  logic                             pop,
  output logic [DATA_W-1:0]                head,
  output logic [$clog2(DEPTH+1)-1:0]       count,
  output logic                             full,
  output logic                             nonempty
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH+1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH-1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;
  logic [CNT_W-1:0]  cnt_q;
  logic              pop_ok, push_ok;

  assign pop_ok   = pop && (cnt_q != '0);
  assign push_ok  = push && ((cnt_q != FULL_CNT) || pop_ok);
  assign head     = mem[rd_ptr];
  assign count    = cnt_q;
  assign full     = (cnt_q == FULL_CNT);
  assign nonempty = (cnt_q != '0);

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt_q  <= '0;
    end else begin
      if (push_ok) wr_ptr <= (wr_ptr == LAST_PTR) ? '0 : wr_ptr + 1'b1;
      if (pop_ok)  rd_ptr <= (rd_ptr == LAST_PTR) ? '0 : rd_ptr + 1'b1;
      case ({push_ok, pop_ok})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= FULL_CNT);
  assert_full_drop_R4: assert property (@(posedge clk) disable iff (rst)
    (push && !pop && cnt_q == FULL_CNT) |=> $stable(cnt_q));
  assert_empty_pop_R4: assert property (@(posedge clk) disable iff (rst)
    (pop && !push && cnt_q == '0) |=> (cnt_q == '0));
  assert_push_pop_R10: assert property (@(posedge clk) disable iff (rst)
    (push && pop && cnt_q != '0) |=> $stable(cnt_q));
endmodule

// File: rtl/mbox_irq_bank.sv
module mbox_irq_bank #(
  parameter int unsigned NCH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NCH-1:0]   set_rx,
  input  logic [NCH-1:0]   set_tx,
  input  logic [NCH-1:0]   hold_rx,
  input  logic             en_we,
  input  logic [2*NCH-1:0] en_wdata,
  input  logic             clr_we,
  input  logic [2*NCH-1:0] clr_mask,
  output logic [2*NCH-1:0] status,
  output logic [2*NCH-1:0] enable,
  output logic             irq
);
  localparam int unsigned IRQ_W = 2*NCH;

  logic [IRQ_W-1:0] set_v, keep_v, clr_v;

  always_comb begin
    for (int i = 0; i < NCH; i++) begin
      set_v[2*i]    = set_rx[i];
      set_v[2*i+1]  = set_tx[i];
      keep_v[2*i]   = hold_rx[i];
      keep_v[2*i+1] = 1'b0;
    end
    clr_v = clr_we ? (clr_mask & ~keep_v) : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status <= '0;
      enable <= '0;
      irq    <= 1'b0;
    end else begin
      status <= (status & ~clr_v) | set_v;
      if (en_we) enable <= en_wdata;
      irq <= |(status & enable);
    end
  end

  for (genvar i = 0; i < NCH; i++) begin : g_chk
    assert_rx_hold_R6: assert property (@(posedge clk) disable iff (rst)
      $fell(status[2*i]) |-> !$past(hold_rx[i]));
    assert_tx_room_R7: assert property (@(posedge clk) disable iff (rst)
      set_tx[i] |=> status[2*i+1]);
  end
endmodule

// File: rtl/ipc_mailbox.sv
module ipc_mailbox import mbox_pkg::*; #(
  parameter int unsigned NCH    = 8,
  parameter int unsigned DEPTH  = 4,
  parameter int unsigned DATA_W = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 a_req,
  input  logic                 a_we,
  input  logic [MB_ADDR_W-1:0] a_addr,
  input  logic [DATA_W-1:0]    a_wdata,
  output logic [DATA_W-1:0]    a_rdata,
  output logic                 a_irq,
  input  logic                 b_req,
  input  logic                 b_we,
  input  logic [MB_ADDR_W-1:0] b_addr,
  input  logic [DATA_W-1:0]    b_wdata,
  output logic [DATA_W-1:0]    b_rdata,
  output logic                 b_irq
);
  localparam int unsigned IRQ_W = 2*NCH;
  localparam int unsigned CNT_W = $clog2(DEPTH+1);

  logic [1:0]        req_v, we_v;
  logic [DATA_W-1:0] wdata_v [2];
  logic [DATA_W-1:0] rdata_v [2];
  dec_t              dec     [2];

  assign req_v      = {b_req, a_req};
  assign we_v       = {b_we, a_we};
  assign wdata_v[0] = a_wdata;
  assign wdata_v[1] = b_wdata;
  assign dec[0]     = decode(a_addr);
  assign dec[1]     = decode(b_addr);
  assign a_rdata    = rdata_v[0];
  assign b_rdata    = rdata_v[1];

  // dir_q[n] = 1: side B sends on channel n, side A receives.
  logic [NCH-1:0] dir_q;
  logic [NCH-1:0] rx_side [2];
  assign rx_side[0] = dir_q;
  assign rx_side[1] = ~dir_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q <= '0;
    end else begin
      for (int n = 0; n < NCH; n++) begin
        for (int s = 1; s >= 0; s--) begin
          if (req_v[s] && we_v[s] && dec[s].kind == RG_CTRL &&
              dec[s].idx == 4'(n/4) &&
              (wdata_v[s][8*(n%4)] != wdata_v[s][8*(n%4)+4]))
            dir_q[n] <= (s == 0) ? wdata_v[s][8*(n%4)] : wdata_v[s][8*(n%4)+4];
        end
      end
    end
  end

  // Channel FIFOs
  logic [NCH-1:0]    push_req, pop_req, full_v, nonempty_v;
  logic [DATA_W-1:0] push_data [NCH];
  logic [DATA_W-1:0] head_v    [NCH];
  logic [CNT_W-1:0]  cnt_v     [NCH];

  always_comb begin
    for (int n = 0; n < NCH; n++) begin
      push_req[n] = 1'b0;
      pop_req[n]  = 1'b0;
      for (int s = 0; s < 2; s++) begin
        if (req_v[s] && dec[s].kind == RG_DATA && dec[s].idx == 4'(n)) begin
          if (we_v[s]) push_req[n] = push_req[n] | ~rx_side[s][n];
          else         pop_req[n]  = pop_req[n]  |  rx_side[s][n];
        end
      end
    end
  end

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    assign push_data[n] = dir_q[n] ? wdata_v[1] : wdata_v[0];

    mbox_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
      .clk      (clk),
      .rst      (rst),
      .push     (push_req[n]),
      .push_data(push_data[n]),
      .pop      (pop_req[n]),
      .head     (head_v[n]),
      .count    (cnt_v[n]),
      .full     (full_v[n]),
      .nonempty (nonempty_v[n])
    );

    assert_wrong_side_R5: assert property (@(posedge clk) disable iff (rst)
      (req_v[0] && we_v[0] && dec[0].kind == RG_DATA && dec[0].idx == 4'(n) &&
       dir_q[n] && !req_v[1]) |=> $stable(cnt_v[n]));
  end

  // Per-side interrupt banks and read paths
  logic [IRQ_W-1:0] stat_v [2];
  logic [IRQ_W-1:0] en_v   [2];
  logic [1:0]       irq_v;

  assign a_irq = irq_v[0];
  assign b_irq = irq_v[1];

  for (genvar s = 0; s < 2; s++) begin : g_side
    localparam int OS = 1 - s;
    logic [DATA_W-1:0] rd_d, rd_q;

    mbox_irq_bank #(.NCH(NCH)) u_bank (
      .clk     (clk),
      .rst     (rst),
      .set_rx  (rx_side[s] & nonempty_v),
      .set_tx  (~rx_side[s] & ~full_v),
      .hold_rx (nonempty_v),
      .en_we   (req_v[s] && we_v[s] && dec[s].kind == RG_OWN_EN),
      .en_wdata(wdata_v[s][IRQ_W-1:0]),
      .clr_we  (req_v[s] && we_v[s] && dec[s].kind == RG_OWN_ST),
      .clr_mask(wdata_v[s][IRQ_W-1:0]),
      .status  (stat_v[s]),
      .enable  (en_v[s]),
      .irq     (irq_v[s])
    );

    always_comb begin
      rd_d = '0;
      if (req_v[s] && !we_v[s]) begin
        case (dec[s].kind)
          RG_CTRL: begin
            for (int n = 0; n < NCH; n++) begin
              if (dec[s].idx == 4'(n/4)) begin
                rd_d[8*(n%4)]   = rx_side[s][n];
                rd_d[8*(n%4)+4] = ~rx_side[s][n];
              end
            end
          end
          RG_PEER_EN: rd_d = DATA_W'(en_v[OS]);
          RG_PEER_ST: rd_d = DATA_W'(stat_v[OS]);
          RG_OWN_EN:  rd_d = DATA_W'(en_v[s]);
          RG_OWN_ST:  rd_d = DATA_W'(stat_v[s]);
          RG_FULL: begin
            for (int n = 0; n < NCH; n++)
              if (dec[s].idx == 4'(n)) rd_d[0] = full_v[n];
          end
          RG_CNT: begin
            for (int n = 0; n < NCH; n++)
              if (dec[s].idx == 4'(n)) rd_d = DATA_W'(cnt_v[n]);
          end
          RG_DATA: begin
            for (int n = 0; n < NCH; n++)
              if (dec[s].idx == 4'(n) && rx_side[s][n] && nonempty_v[n])
                rd_d = head_v[n];
          end
          default: rd_d = '0;
        endcase
      end
    end

    always_ff @(posedge clk) begin
      if (rst) rd_q <= '0;
      else     rd_q <= rd_d;
    end

    assign rdata_v[s] = rd_q;
  end
endmodule

// File: tb/ipc_mailbox_tb.sv
`timescale 1ns/1ps
module ipc_mailbox_tb;
  logic        clk = 1'b0, rst = 1'b1;
  logic        a_req = 0, a_we = 0, b_req = 0, b_we = 0;
  logic [9:0]  a_addr = '0, b_addr = '0;
  logic [31:0] a_wdata = '0, b_wdata = '0;
  logic [31:0] a_rdata, b_rdata;
  logic        a_irq, b_irq;

  ipc_mailbox u_dut (
    .clk(clk), .rst(rst),
    .a_req(a_req), .a_we(a_we), .a_addr(a_addr), .a_wdata(a_wdata),
    .a_rdata(a_rdata), .a_irq(a_irq),
    .b_req(b_req), .b_we(b_we), .b_addr(b_addr), .b_wdata(b_wdata),
    .b_rdata(b_rdata), .b_irq(b_irq)
  );

  always #2 clk = ~clk;

  int total = 0, bad = 0;

  // Reference model: dirm[n]=1 means side B sends on channel n.
  int          dirm [8];
  int          cntm [8];
  logic [31:0] qm   [8][4];
  logic [15:0] stm  [2];
  logic [15:0] enm  [2];

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic bit rxs(int s, int n);
    return dirm[n] != s;
  endfunction

  function automatic logic [9:0] ad_ctrl(int w); return 10'(4*w);       endfunction
  function automatic logic [9:0] ad_full(int n); return 10'(256 + 4*n); endfunction
  function automatic logic [9:0] ad_cnt(int n);  return 10'(320 + 4*n); endfunction
  function automatic logic [9:0] ad_data(int n); return 10'(384 + 4*n); endfunction

  task automatic settle();
    for (int s = 0; s < 2; s++)
      for (int n = 0; n < 8; n++) begin
        if (rxs(s, n) && cntm[n] > 0) stm[s][2*n]   = 1'b1;
        if (!rxs(s, n) && cntm[n] < 4) stm[s][2*n+1] = 1'b1;
      end
  endtask

  task automatic model_op(int s, bit we, logic [9:0] ad, logic [31:0] wd,
                          output logic [31:0] rd);
    int w = int'(ad[9:2]);
    rd = '0;
    if (w < 2) begin
      for (int j = 0; j < 4; j++) begin
        int n = 4*w + j;
        if (we) begin
          if (wd[8*j] != wd[8*j+4]) dirm[n] = (s == 0) ? int'(wd[8*j]) : int'(wd[8*j+4]);
        end else begin
          rd[8*j]   = rxs(s, n);
          rd[8*j+4] = !rxs(s, n);
        end
      end
    end else if (w == 16) begin
      if (!we) rd = {16'd0, enm[1-s]};
    end else if (w == 20) begin
      if (!we) rd = {16'd0, stm[1-s]};
    end else if (w == 24) begin
      if (we) enm[s] = wd[15:0]; else rd = {16'd0, enm[s]};
    end else if (w == 28) begin
      if (we) begin
        for (int b = 0; b < 16; b++)
          if (wd[b] && !((b % 2 == 0) && cntm[b/2] > 0)) stm[s][b] = 1'b0;
      end else rd = {16'd0, stm[s]};
    end else if (w >= 64 && w < 72) begin
      if (!we) rd = {31'd0, cntm[w-64] == 4};
    end else if (w >= 80 && w < 88) begin
      if (!we) rd = 32'(cntm[w-80]);
    end else if (w >= 96 && w < 104) begin
      int n = w - 96;
      if (we) begin
        if (!rxs(s, n) && cntm[n] < 4) begin
          qm[n][cntm[n]] = wd;
          cntm[n]++;
        end
      end else if (rxs(s, n) && cntm[n] > 0) begin
        rd = qm[n][0];
        for (int k = 0; k < 3; k++) qm[n][k] = qm[n][k+1];
        cntm[n]--;
      end
    end
  endtask

  task automatic acc2(bit va, bit wa, logic [9:0] aa, logic [31:0] da,
                      bit vb, bit wb, logic [9:0] ab, logic [31:0] db,
                      output logic [31:0] ra, output logic [31:0] rb);
    @(negedge clk);
    a_req = va; a_we = wa; a_addr = aa; a_wdata = da;
    b_req = vb; b_we = wb; b_addr = ab; b_wdata = db;
    @(negedge clk);
    ra = a_rdata; rb = b_rdata;
    a_req = 0; a_we = 0; b_req = 0; b_we = 0;
    repeat (3) @(negedge clk);
  endtask

  task automatic check_irq(string tag);
    chk({tag, " irqA"}, {31'd0, a_irq}, {31'd0, |(stm[0] & enm[0])});
    chk({tag, " irqB"}, {31'd0, b_irq}, {31'd0, |(stm[1] & enm[1])});
  endtask

  task automatic do_op(int s, bit we, logic [9:0] ad, logic [31:0] wd, string tag);
    logic [31:0] ra, rb, ex;
    if (s == 0) acc2(1, we, ad, wd, 0, 0, '0, '0, ra, rb);
    else        acc2(0, 0, '0, '0, 1, we, ad, wd, ra, rb);
    model_op(s, we, ad, wd, ex);
    settle();
    if (!we) chk(tag, (s == 0) ? ra : rb, ex);
    check_irq("R8");
  endtask

  // A pushes, B pops, same channel, same cycle (B sends when dirm=1 is not used here).
  task automatic both_op(int n, logic [31:0] wd, string tag);
    logic [31:0] ra, rb, ex, dummy;
    acc2(1, 1, ad_data(n), wd, 1, 0, ad_data(n), '0, ra, rb);
    model_op(1, 0, ad_data(n), '0, ex);
    model_op(0, 1, ad_data(n), wd, dummy);
    settle();
    chk(tag, rb, ex);
    check_irq("R8");
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd20240611));
    for (int n = 0; n < 8; n++) begin dirm[n] = 0; cntm[n] = 0; end
    stm[0] = '0; stm[1] = '0; enm[0] = '0; enm[1] = '0;

    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 irqA after reset", {31'd0, a_irq}, 32'd0);
    chk("R1 irqB after reset", {31'd0, b_irq}, 32'd0);
    settle();
    do_op(0, 0, ad_cnt(0), '0, "R1 count");
    do_op(0, 0, ad_ctrl(0), '0, "R1 ctrl A");
    do_op(1, 0, ad_ctrl(1), '0, "R1 ctrl B");
    do_op(0, 0, 10'h060, '0, "R1 enable A");
    do_op(0, 0, 10'h070, '0, "R1 status A");

    // R2: B takes sender role on channel 1; both-bits write on channel 0 ignored
    do_op(1, 1, ad_ctrl(0), 32'h0000_1011, "R2");
    do_op(0, 0, ad_ctrl(0), '0, "R2 ctrl view A");
    do_op(1, 0, ad_ctrl(0), '0, "R2 ctrl view B");

    // R3/R4: fill channel 1 from B, overflow dropped
    for (int k = 0; k < 5; k++) do_op(1, 1, ad_data(1), 32'hC0DE_0000 + k, "R4 push");
    do_op(0, 0, ad_cnt(1), '0, "R3 count full");
    do_op(0, 0, ad_full(1), '0, "R3 full flag");
    // R6: clear of rx bit blocked while non-empty
    do_op(0, 1, 10'h070, 32'h0000_0004, "R6");
    do_op(0, 0, 10'h070, '0, "R6 blocked");
    do_op(1, 0, 10'h050, '0, "R9 peer status");
    // R5: wrong-side accesses
    do_op(0, 1, ad_data(1), 32'hDEAD_BEEF, "R5 rx write");
    do_op(1, 0, ad_data(1), '0, "R5 tx read");
    do_op(0, 0, ad_cnt(1), '0, "R5 count");
    for (int k = 0; k < 5; k++) do_op(0, 0, ad_data(1), '0, "R3 pop order");
    do_op(0, 0, ad_data(1), '0, "R4 empty pop");
    do_op(0, 1, 10'h070, 32'h0000_0004, "R6 clear");
    do_op(0, 0, 10'h070, '0, "R6 cleared");
    do_op(1, 0, 10'h050, '0, "R9 ack seen");
    // R7: tx bit clears then returns
    do_op(1, 1, 10'h070, 32'h0000_0008, "R7");
    do_op(1, 0, 10'h070, '0, "R7 tx back");
    // R9: writes to peer registers ignored
    do_op(0, 1, 10'h040, 32'h0000_FFFF, "R9");
    do_op(0, 1, 10'h050, 32'h0000_FFFF, "R9");
    do_op(1, 0, 10'h060, '0, "R9 B enable");
    do_op(0, 0, 10'h050, '0, "R9 B status");
    // R8: enable and interrupt line
    do_op(1, 1, 10'h060, 32'h0000_0008, "R8");
    do_op(0, 0, 10'h040, '0, "R8 peer enable");
    do_op(1, 1, 10'h060, 32'h0000_0000, "R8");
    // R10: channel 2 (A sends, B receives)
    both_op(2, 32'h1111_2222, "R10 empty");
    do_op(0, 0, ad_cnt(2), '0, "R10 count 1");
    for (int k = 0; k < 3; k++) do_op(0, 1, ad_data(2), 32'hAB00_0000 + k, "R10 fill");
    both_op(2, 32'h5555_6666, "R10 full");
    do_op(1, 0, ad_cnt(2), '0, "R10 count 4");
    for (int k = 0; k < 4; k++) do_op(1, 0, ad_data(2), '0, "R10 order");

    // Constrained random mix
    for (int it = 0; it < 400; it++) begin
      int op = $urandom % 10;
      int s  = $urandom % 2;
      int n  = $urandom % 8;
      case (op)
        0, 1, 2: do_op(s, 1, ad_data(n), $urandom, "R3 rand push");
        3, 4:    do_op(s, 0, ad_data(n), '0, "R3 rand pop");
        5:       do_op(s, 0, ($urandom % 2) ? ad_cnt(n) : ad_full(n), '0, "R3 rand stat");
        6:       do_op(s, 0, ($urandom % 2) ? 10'h050 : 10'h070, '0, "R7 rand status");
        7:       do_op(s, 1, 10'h070, $urandom & 32'hFFFF, "R6 rand clear");
        8:       if ($urandom % 3 == 0) do_op(s, 1, ad_ctrl(n % 2), $urandom & 32'h1111_1111, "R2 rand dir");
                 else do_op(s, 0, ad_ctrl(n % 2), '0, "R2 rand ctrl");
        default: do_op(s, 1, 10'h060, $urandom & 32'hFFFF, "R8 rand enable");
      endcase
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule